// File: doc/BRIEF.md
# Tick-Aligned Timemark Pulse Generator

This block emits single-clock timemark pulses that line up with a periodic tick strobe. The tick arrives already synchronous to the block clock as a one-cycle strobe marking each tick rising edge. The pulse is raised in the same clock cycle as the tick strobe that triggers it.

Software steers the block through one write-only control word. It holds a one-shot arm request, a free-run enable and a 5-bit repetition ratio. In one-shot mode an arming write schedules exactly one pulse on the next tick, and the request then clears itself. In free-run mode the first tick after enabling produces a pulse. After that a pulse fires every ratio+1 ticks, counted by a tick down-counter that is reloaded with the ratio on each pulse.

Top module: `tmg_timemark`

## Requirements
- R1: A control write (`wr_en` high) loads bit 0 as the arm request, bit 1 as the free-run enable and bits 6:2 as the ratio. Bits 15:7 are ignored.
- R2: With free-run off, an arming write causes exactly one pulse, on the first tick strobe after the write cycle. The pulse lasts one clock, in the same cycle as that strobe.
- R3: The arm request clears when its pulse fires, so later ticks produce no pulse until a new arming write.
- R4: While free-run is enabled, or when the same write sets free-run, the arm bit has no effect. A free-run write also cancels an arm request that is still pending.
- R5: After a write turns free-run on from off, the first tick strobe in a later cycle produces a pulse.
- R6: After each free-run pulse, the next pulse comes exactly ratio+1 ticks later.
- R7: After reset the block is in one-shot mode, not armed, with ratio 0, and no tick produces a pulse.
- R8: An arming write in the same cycle as a tick strobe produces no pulse in that cycle; the pulse comes on the following tick. This also holds when the write lands on the tick that fires an earlier arm request.
- R9: A write that clears free-run stops free-run pulses from the next cycle on. Enabling free-run again restarts alignment as in R5.
- R10: A ratio written during free-run does not shorten or lengthen the period in progress; it applies from the next pulse on.
- R11: The pulse is never high in a cycle without a tick strobe.
- R12: A write with bit 0 low leaves a pending arm request intact, unless it sets free-run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word: bit 0 arm, bit 1 free-run, bits 6:2 ratio |
| tick | input | 1 | One-cycle strobe marking a tick rising edge |
| pulse | output | 1 | Timemark pulse, one clock wide |

## Verification
The bench builds the block with its defaults: a 16-bit control word and a 5-bit ratio. With these values the largest ratio of 31 is within reach, and a full 32-tick free-run period is checked, as are ratio 0 with ticks on consecutive cycles. Because ticks are one-cycle strobes with adjustable gaps, arming writes, ratio changes and free-run stops can land exactly on a tick cycle, which is where the deferral and precedence rules matter.

// File: rtl/tmg_pkg.sv
package tmg_pkg;
  // Control word field positions (software visible)
  localparam int unsigned ARM_POS   = 0;
  localparam int unsigned FRUN_POS  = 1;
  localparam int unsigned RATIO_LSB = 2;
endpackage

// File: rtl/tmg_ctrl_reg.sv
module tmg_ctrl_reg
  import tmg_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               frun_q,
  output logic [RATIO_W-1:0] ratio_q,
  output logic               arm_req,
  output logic               arm_cancel,
  output logic               frun_start,
  output logic               frun_stop
);
  localparam int unsigned RATIO_MSB = RATIO_LSB + RATIO_W - 1;

  logic               wr_arm;
  logic               wr_frun;
  logic [RATIO_W-1:0] wr_ratio;

  assign wr_arm   = wr_data[ARM_POS];
  assign wr_frun  = wr_data[FRUN_POS];
  assign wr_ratio = wr_data[RATIO_MSB:RATIO_LSB];

  // decoded write events
  assign arm_req    = wr_en && wr_arm && !wr_frun;
  assign arm_cancel = wr_en && wr_frun;
  assign frun_start = wr_en && wr_frun && !frun_q;
  assign frun_stop  = wr_en && !wr_frun && frun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frun_q  <= 1'b0;
      ratio_q <= '0;
    end else if (wr_en) begin
      frun_q  <= wr_frun;
      ratio_q <= wr_ratio;
    end
  end
endmodule

// File: rtl/tmg_arm_unit.sv
module tmg_arm_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic arm_cancel,
  input  logic frun_q,
  input  logic tick,
  output logic armed_q,
  output logic arm_fire
);
  assign arm_fire = tick && armed_q && !frun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       armed_q <= 1'b0;
    else if (arm_req)                 armed_q <= 1'b1;
    else if (arm_fire || arm_cancel)  armed_q <= 1'b0;
  end
endmodule

// File: rtl/tmg_frun_unit.sv
module tmg_frun_unit #(
  parameter int unsigned RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frun_q,
  input  logic               frun_start,
  input  logic               frun_stop,
  input  logic               tick,
  input  logic [RATIO_W-1:0] ratio_q,
  output logic [RATIO_W-1:0] cnt_q,
  output logic               frun_fire,
  output logic               frun_step
);
  localparam logic [RATIO_W-1:0] CNT_ZERO = '0;

  function automatic logic [RATIO_W-1:0] cnt_next(
    input logic               restart,
    input logic               fire,
    input logic               step,
    input logic [RATIO_W-1:0] cur,
    input logic [RATIO_W-1:0] ratio
  );
    if (restart)   return CNT_ZERO;
    else if (fire) return ratio;
    else if (step) return cur - 1'b1;
    else           return cur;
  endfunction

  assign frun_fire = frun_q && tick && (cnt_q == CNT_ZERO);
  assign frun_step = frun_q && tick && (cnt_q != CNT_ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_ZERO;
    else        cnt_q <= cnt_next(frun_start || frun_stop, frun_fire,
                                  frun_step, cnt_q, ratio_q);
  end
endmodule

// File: rtl/tmg_timemark.sv
module tmg_timemark #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RATIO_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic              pulse
);
  logic               frun_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               arm_req;
  logic               arm_cancel;
  logic               frun_start;
  logic               frun_stop;
  logic               armed_q;
  logic               arm_fire;
  logic [RATIO_W-1:0] cnt_q;
  logic               frun_fire;
  logic               frun_step;

  tmg_ctrl_reg #(.DATA_W(DATA_W), .RATIO_W(RATIO_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .frun_q     (frun_q),
    .ratio_q    (ratio_q),
    .arm_req    (arm_req),
    .arm_cancel (arm_cancel),
    .frun_start (frun_start),
    .frun_stop  (frun_stop)
  );

  tmg_arm_unit u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_req    (arm_req),
    .arm_cancel (arm_cancel),
    .frun_q     (frun_q),
    .tick       (tick),
    .armed_q    (armed_q),
    .arm_fire   (arm_fire)
  );

  tmg_frun_unit #(.RATIO_W(RATIO_W)) u_frun (
    .clk        (clk),
    .rst_n      (rst_n),
    .frun_q     (frun_q),
    .frun_start (frun_start),
    .frun_stop  (frun_stop),
    .tick       (tick),
    .ratio_q    (ratio_q),
    .cnt_q      (cnt_q),
    .frun_fire  (frun_fire),
    .frun_step  (frun_step)
  );

  assign pulse = arm_fire || frun_fire;
endmodule

// File: rtl/tmg_timemark_chk.sv
module tmg_timemark_chk #(
  parameter int unsigned RATIO_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               pulse,
  input logic               frun_q,
  input logic [RATIO_W-1:0] ratio_q,
  input logic               arm_req,
  input logic               frun_start,
  input logic               frun_stop,
  input logic               armed_q,
  input logic               arm_fire,
  input logic [RATIO_W-1:0] cnt_q,
  input logic               frun_fire
);
  p_pulse_needs_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> tick);

  p_arm_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_fire && !arm_req) |=> !armed_q);

  p_frun_masks_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frun_q |-> !arm_fire);

  p_deferred_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && tick && !armed_q && !frun_q) |-> !pulse);

  p_reload_ratio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frun_fire && !frun_stop) |=> (cnt_q == $past(ratio_q)));

  p_first_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frun_start |=> (frun_q && cnt_q == '0));

  p_stopped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frun_stop |=> !frun_fire);
endmodule

bind tmg_timemark tmg_timemark_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .pulse      (pulse),
  .frun_q     (frun_q),
  .ratio_q    (ratio_q),
  .arm_req    (arm_req),
  .frun_start (frun_start),
  .frun_stop  (frun_stop),
  .armed_q    (armed_q),
  .arm_fire   (arm_fire),
  .cnt_q      (cnt_q),
  .frun_fire  (frun_fire)
);

// File: tb/tmg_timemark_test.sv
module tmg_timemark_test;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              tick = 1'b0;
  logic              pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmg_timemark uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .pulse(pulse)
  );

  // bench reference state
  bit m_arm = 0, m_frun = 0, m_first = 0;
  int m_ratio = 0, m_since = 0, m_period = 1;

  typedef struct { bit exp; string tag; } item_t;
  item_t sb[$];

  // control word from fields: arm bit 0, free-run bit 1, ratio bits 6:2
  function automatic logic [15:0] word(bit arm, bit fr, int ratio, int junk = 0);
    return 16'(junk << 7) | 16'((ratio & 31) << 2) | 16'({fr, arm});
  endfunction

  task automatic step(bit we, logic [15:0] d, bit tk, string tag);
    bit e_arm, e_fr, e;
    bit w_arm, w_fr;
    wr_en = we; wr_data = d; tick = tk;
    e_arm = tk && m_arm && !m_frun;
    e_fr  = tk && m_frun && (m_first || (m_since + 1 == m_period));
    e = e_arm || e_fr;
    sb.push_back('{e, tag});
    if (e_arm) m_arm = 0;
    if (e_fr) begin
      m_first = 0; m_since = 0; m_period = m_ratio + 1;
    end else if (tk && m_frun) m_since++;
    if (we) begin
      w_arm = d[0]; w_fr = d[1];
      if (w_fr) m_arm = 0;
      else if (w_arm) m_arm = 1;
      if (w_fr && !m_frun) begin m_first = 1; m_since = 0; end
      if (!w_fr) m_first = 0;
      m_frun = w_fr;
      m_ratio = int'(d[6:2]);
    end
    @(posedge clk); #1;
    wr_en = 0; tick = 0;
  endtask

  task automatic ticks(int n, int gap, string tag);
    for (int i = 0; i < n; i++) begin
      step(0, '0, 1, tag);
      for (int g = 0; g < gap; g++) step(0, '0, 0, tag);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (pulse !== it.exp) begin
        errors++;
        $display("FAIL %s pulse=%b expected=%b at %0t", it.tag, pulse, it.exp, $time);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R7: reset state, ticks give nothing
    ticks(4, 1, "R7 reset idle");
    // R2 / R3: arm then ticks with gaps
    step(1, word(1, 0, 0), 0, "R2 arm write");
    step(0, '0, 0, "R2 wait");
    ticks(4, 2, "R2 R3 armed one-shot");
    // R1: junk upper bits, ratio field in one-shot mode
    step(1, word(1, 0, 17, 9'h1AB), 0, "R1 junk bits arm");
    ticks(3, 0, "R1 R2 back-to-back ticks");
    // R8: arm write coincident with tick
    step(1, word(1, 0, 0), 1, "R8 arm on tick");
    ticks(2, 1, "R8 deferred pulse");
    // R8: re-arm on the tick that fires
    step(1, word(1, 0, 0), 0, "R8 arm");
    step(1, word(1, 0, 0), 1, "R8 rearm on firing tick");
    ticks(3, 1, "R8 second pulse");
    // R12: write with bit0 low keeps pending arm
    step(1, word(1, 0, 0), 0, "R12 arm");
    step(1, word(0, 0, 5), 0, "R12 write arm=0");
    ticks(2, 1, "R12 pending kept");
    // R4: arm with free-run in same write
    step(1, word(1, 1, 2), 0, "R4 arm+frun");
    step(0, '0, 0, "R4 wait");
    // R5/R6 ratio 2
    ticks(10, 1, "R5 R6 free-run ratio 2");
    // R4: arm writes while free-running
    step(1, word(1, 1, 2), 1, "R4 arm during frun");
    ticks(5, 0, "R4 R6 frun continues");
    // R10: ratio change mid-period
    step(1, word(0, 1, 4), 0, "R10 ratio 4 mid-run");
    ticks(14, 1, "R10 new ratio at reload");
    // R9: stop on a tick cycle
    step(1, word(0, 0, 4), 1, "R9 stop on tick");
    ticks(6, 0, "R9 stopped");
    // R4: pending arm cancelled by free-run write, then stop
    step(1, word(1, 0, 0), 0, "R4 arm before frun");
    step(1, word(0, 1, 0), 0, "R4 frun cancels arm");
    ticks(4, 0, "R5 R6 ratio 0 every tick");
    step(1, word(0, 0, 0), 0, "R9 stop");
    ticks(3, 0, "R4 R9 no pending arm");
    // R5: enable on a tick cycle, then max ratio
    step(1, word(0, 1, 31), 1, "R5 enable on tick");
    ticks(70, 0, "R6 ratio 31");
    step(1, word(0, 0, 0), 0, "R9 stop");
    ticks(3, 1, "R9 quiet");
    // R9: re-enable restarts alignment
    step(1, word(0, 1, 3), 0, "R9 re-enable");
    ticks(9, 2, "R9 R5 R6 restart");
    step(0, '0, 0, "drain");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule